// File: doc/BRIEF.md
# Variable-Cycle Microsequencer with Writable Control Store

This block steps through a horizontal microprogram held in a small control store that a host can rewrite while the sequencer runs. Each stored word is wide and unencoded: separate bit groups drive an ALU operation code, a register-file path select, a memory request strobe and a per-access cacheable marker. The datapath units themselves sit outside. They see only these control outputs and return a single condition flag.

Every microinstruction carries a 2-bit duration code, so it occupies 5, 6, 7 or 8 clock ticks. The sequencer holds the word's fields on its outputs for that whole span. On the final tick it chooses the next address and fetches that word. The next address can be the following location, an unconditional target, or a target taken only when the flag is set or only when it is clear. A one-clock strobe marks the last tick of every microinstruction, so downstream logic and test benches can align to the boundaries.

A host load port writes any control-store word at any time, including the word that is currently executing. A change only takes hold the next time that address is fetched.

Top module: `useq_core`

## Requirements
- R1: Each microinstruction lasts exactly 5 + d clock cycles, where d is the duration code in word bits [1:0] (d = 0..3 gives 5..8 cycles).
- R2: `cyc_done` is high for exactly one clock, the last cycle of each microinstruction. `upc` and all control outputs change only on the clock edge that follows that cycle.
- R3: `alu_ctl` equals word bits [11:8], `rf_sel` equals bits [14:12] and `mem_req` equals bit [15] of the current word. These fields are held for its whole duration and are decoded independently of the sequencing fields.
- R4: `mem_cacheable` equals bit [16] of the current word, so cacheability is chosen per microinstruction.
- R5: Sequencing kind in bits [3:2]: 0 moves to `upc`+1, wrapping from the last address to 0. 1 jumps to the target in bits [7:4].
- R6: Kind 2 jumps to the target if `cond_flag` is 1, and kind 3 jumps to the target if `cond_flag` is 0; otherwise both move to `upc`+1. The flag is sampled only in the last cycle of the microinstruction.
- R7: While `rst` is high (synchronous, active high), `upc`, all control outputs and `cyc_done` are 0. The word at address 0 is fetched on the first clock edge with `rst` low, and its fields appear after that edge. Reset does not clear the control store.
- R8: A host write (`ld_en`, `ld_addr`, `ld_word`) is accepted on any clock edge, during reset as well. It never alters the microinstruction in progress. A write on the same edge that fetches the written address delivers the old word, and the new word is used from the following fetch of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_flag | input | 1 | Condition flag from the ALU |
| ld_en | input | 1 | Host write enable for the control store |
| ld_addr | input | 4 | Host write address |
| ld_word | input | 17 | Host write data (microinstruction word) |
| alu_ctl | output | 4 | ALU operation field of the current word |
| rf_sel | output | 3 | Register-file path select field |
| mem_req | output | 1 | Memory access request field |
| mem_cacheable | output | 1 | Marks the memory access as cacheable |
| upc | output | 4 | Address of the current microinstruction |
| cyc_done | output | 1 | Pulses in the last cycle of each microinstruction |

## Verification
The embedded assertions check the following on every clock:
- The tick count never passes the current word's limit and restarts after the last tick.
- The fields and address stay frozen until the boundary.
- Increment, jump and flag-taken branches land on the right address.
- Reset clears the visible state.

Only the bench's scenarios can show the remaining behaviour:
- The duration measured between strobes is exact for all four codes.
- The output fields match what was written.
- A not-taken conditional falls through.
- Host writes to the running address, including writes on the fetch edge itself, leave the current microinstruction untouched and take effect only on the following fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W    = 4;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int ALU_W     = 4;
    localparam int RSEL_W    = 3;
    localparam int DUR_W     = 2;
    localparam int MIN_TICKS = 5;
    localparam int MAX_TICKS = MIN_TICKS + (1 << DUR_W) - 1;
    localparam int TICK_W    = $clog2(MAX_TICKS);

    typedef enum logic [1:0] {
        SEQ_INC  = 2'd0,
        SEQ_JMP  = 2'd1,
        SEQ_JSET = 2'd2,
        SEQ_JCLR = 2'd3
    } seq_e;

    // Packed MSB first; the dur field sits at bit 0.
    typedef struct packed {
        logic              cacheable;
        logic              mem_req;
        logic [RSEL_W-1:0] rsel;
        logic [ALU_W-1:0]  alu_op;
        logic [ADDR_W-1:0] target;
        seq_e              seq;
        logic [DUR_W-1:0]  dur;
    } uword_t;

    localparam int WORD_W = $bits(uword_t);

    function automatic logic [TICK_W-1:0] last_tick(input logic [DUR_W-1:0] d);
        return TICK_W'(MIN_TICKS - 1) + TICK_W'(d);
    endfunction

    function automatic logic [ADDR_W-1:0] pick_next(
        input logic [ADDR_W-1:0] pc,
        input seq_e              kind,
        input logic [ADDR_W-1:0] tgt,
        input logic              flag
    );
        logic take;
        case (kind)
            SEQ_JMP:  take = 1'b1;
            SEQ_JSET: take = flag;
            SEQ_JCLR: take = ~flag;
            default:  take = 1'b0;
        endcase
        return take ? tgt : pc + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int AW = 4,
    parameter int W  = 17
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Read sees the array before this edge's write: read-before-write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  logic [ADDR_W-1:0] pc,
    input  seq_e              seq,
    input  logic [ADDR_W-1:0] target,
    input  logic              flag,
    output logic [ADDR_W-1:0] nxt
);
    always_comb nxt = pick_next(pc, seq, target, flag);
endmodule

// File: rtl/useq_timer.sv
module useq_timer
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DUR_W-1:0] dur,
    output logic             last
);
    logic [TICK_W-1:0] tick;

    assign last = run && (tick == last_tick(dur));

    always_ff @(posedge clk) begin
        if (rst || !run || last) tick <= '0;
        else                     tick <= tick + TICK_W'(1);
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (tick <= last_tick(dur)));  // R1
    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (rst)
        last |=> (tick == '0));  // R2

endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cond_flag,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_word,
    output logic [ALU_W-1:0]  alu_ctl,
    output logic [RSEL_W-1:0] rf_sel,
    output logic              mem_req,
    output logic              mem_cacheable,
    output logic [ADDR_W-1:0] upc,
    output logic              cyc_done
);
    logic              valid;
    logic              last;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] nxt_pc;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    uword_t            cur_q;

    useq_store #(.AW(ADDR_W), .W(WORD_W)) u_store (
        .clk   (clk),
        .we    (ld_en),
        .waddr (ld_addr),
        .wdata (ld_word),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    useq_next u_next (
        .pc     (pc_q),
        .seq    (cur_q.seq),
        .target (cur_q.target),
        .flag   (cond_flag),
        .nxt    (nxt_pc)
    );

    useq_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (valid),
        .dur  (cur_q.dur),
        .last (last)
    );

    // First fetch after reset reads address 0 (pc_q), later fetches the chosen successor.
    assign rd_addr = valid ? nxt_pc : pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            pc_q  <= '0;
            cur_q <= '0;
        end else if (!valid || last) begin
            valid <= 1'b1;
            pc_q  <= rd_addr;
            cur_q <= uword_t'(rd_word);
        end
    end

    assign alu_ctl       = cur_q.alu_op;
    assign rf_sel        = cur_q.rsel;
    assign mem_req       = cur_q.mem_req;
    assign mem_cacheable = cur_q.cacheable;
    assign upc           = pc_q;
    assign cyc_done      = last;

    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (valid && !last) |=> $stable(cur_q));  // R3
    AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
        (valid && !last) |=> $stable(pc_q));  // R2
    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (valid && last && cur_q.seq == SEQ_INC) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));  // R5
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (valid && last && cur_q.seq == SEQ_JMP) |=> (pc_q == $past(cur_q.target)));  // R5
    AST_BRANCH_SET: assert property (@(posedge clk) disable iff (rst)
        (valid && last && cur_q.seq == SEQ_JSET && cond_flag) |=> (pc_q == $past(cur_q.target)));  // R6
    AST_BRANCH_CLR: assert property (@(posedge clk) disable iff (rst)
        (valid && last && cur_q.seq == SEQ_JCLR && !cond_flag) |=> (pc_q == $past(cur_q.target)));  // R6
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && cur_q == '0 && !cyc_done));  // R7

endmodule

// File: tb/useq_core_bench.sv
module useq_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cond_flag = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [16:0] ld_word = '0;
    logic [3:0]  alu_ctl;
    logic [2:0]  rf_sel;
    logic        mem_req;
    logic        mem_cacheable;
    logic [3:0]  upc;
    logic        cyc_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [16:0] mem_m [16];
    logic [16:0] ew;
    int          ep;
    int          etick;
    int          act_cnt;
    string       upc_tag;
    bit          hit_cur;

    useq_core u_useq_core (
        .clk(clk), .rst(rst), .cond_flag(cond_flag), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_word(ld_word), .alu_ctl(alu_ctl),
        .rf_sel(rf_sel), .mem_req(mem_req), .mem_cacheable(mem_cacheable),
        .upc(upc), .cyc_done(cyc_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int f_dur(logic [16:0] w);   return int'(w[1:0]);   endfunction
    function automatic int f_kind(logic [16:0] w);  return int'(w[3:2]);   endfunction
    function automatic int f_tgt(logic [16:0] w);   return int'(w[7:4]);   endfunction
    function automatic int f_alu(logic [16:0] w);   return int'(w[11:8]);  endfunction
    function automatic int f_rsel(logic [16:0] w);  return int'(w[14:12]); endfunction
    function automatic int f_req(logic [16:0] w);   return int'(w[15]);    endfunction
    function automatic int f_cache(logic [16:0] w); return int'(w[16]);    endfunction

    function automatic int exp_next(logic [16:0] w, int pc, bit flag);
        int k = f_kind(w);
        bit take = (k == 1) || (k == 2 && flag) || (k == 3 && !flag);
        return take ? f_tgt(w) : (pc + 1) % 16;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_reset_outputs();
        chk(upc == 4'd0, "R7", "upc in reset", int'(upc), 0);
        chk(alu_ctl == 4'd0 && rf_sel == 3'd0 && !mem_req && !mem_cacheable,
            "R7", "control outputs in reset",
            int'({mem_cacheable, mem_req, rf_sel, alu_ctl}), 0);
        chk(!cyc_done, "R7", "cyc_done in reset", int'(cyc_done), 0);
    endtask

    // Called at a negedge right after the first fetch edge.
    task automatic model_start();
        ep = 0; ew = mem_m[0]; etick = 0; act_cnt = 0;
        upc_tag = "R7"; hit_cur = 0;
    endtask

    task automatic step(int wr_pct);
        int  d    = f_dur(ew);
        bit  edone = (etick == 4 + d);
        string ftag = hit_cur ? "R8" : "R3";
        bit  fl;
        bit  wr;
        int  wa;
        logic [16:0] wd;

        chk(int'(alu_ctl) == f_alu(ew), ftag, "alu_ctl", int'(alu_ctl), f_alu(ew));
        chk(int'(rf_sel) == f_rsel(ew), ftag, "rf_sel", int'(rf_sel), f_rsel(ew));
        chk(int'(mem_req) == f_req(ew), ftag, "mem_req", int'(mem_req), f_req(ew));
        chk(int'(mem_cacheable) == f_cache(ew), hit_cur ? "R8" : "R4", "mem_cacheable",
            int'(mem_cacheable), f_cache(ew));
        chk(int'(upc) == ep, upc_tag, "upc", int'(upc), ep);
        chk(cyc_done == edone, "R2", "cyc_done", int'(cyc_done), int'(edone));
        act_cnt++;
        if (cyc_done) begin
            chk(act_cnt == 5 + d, "R1", "cycles per microinstruction", act_cnt, 5 + d);
            act_cnt = 0;
        end

        fl = 1'($urandom_range(0, 1));
        wr = ($urandom_range(0, 99) < wr_pct);
        wa = ($urandom_range(0, 1) == 1) ? ep : int'($urandom_range(0, 15));
        wd = 17'($urandom);

        if (edone) begin
            int np = exp_next(ew, ep, fl);
            upc_tag = (f_kind(ew) < 2) ? "R5" : "R6";
            ew = mem_m[np];         // fetch sees the store before this edge's write (R8)
            ep = np; etick = 0; hit_cur = 0;
        end else begin
            etick++;
        end
        if (wr && wa == ep) hit_cur = 1;  // R8: write to the address in flight
        if (wr) mem_m[wa] = wd;

        cond_flag = fl;
        ld_en     = wr;
        ld_addr   = 4'(wa);
        ld_word   = wd;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // Load program during reset: addresses 0..3 sweep all duration codes with kind 0.
        for (int a = 0; a < 16; a++) begin
            logic [16:0] w = 17'($urandom);
            if (a < 4) begin
                w[1:0] = 2'(a);
                w[3:2] = 2'd0;
            end
            mem_m[a] = w;
            ld_en = 1'b1; ld_addr = 4'(a); ld_word = w;
            @(negedge clk);
            check_reset_outputs();  // R7
        end
        ld_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        model_start();
        // Directed: quiet run through the four duration codes, no writes.
        for (int i = 0; i < 40; i++) step(0);
        // Random program mutation and flags.
        for (int i = 0; i < RUN_CYCLES; i++) step(15);
        // Mid-run reset: store contents must survive (R7).
        ld_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check_reset_outputs();
        @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        @(negedge clk);
        model_start();
        for (int i = 0; i < 1000; i++) step(30);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule